// File: doc/BRIEF.md
# Unlock-sequence command decoder

This block sits in front of a one-time-programmable memory array. It turns a stream of bus writes into operations for that array. Each write is marked by a one-cycle valid pulse and carries an address and a data word. A command begins with a two-write unlock key. A third write at the command address then picks what happens next: return to array reads, switch to identification reads, program one word, or start a multi-word programming session. The decoder watches only the low eleven address bits and the low data byte. Any write that does not continue a legal sequence sends it back to the start.

The decoder also owns the read path. In array mode a bus read returns the array data. In identification mode it returns a manufacturer or device code, selected by the two lowest read-address bits. While programming is busy it returns the status word that the external programming engine supplies. Programming starts with a one-cycle request carrying the captured address and data. The engine ends it with a one-cycle done pulse. Writes count only while the programming-voltage-high input is set.

Top module: `cmd_seq_decoder`

## Requirements
- R1: After reset, `mode` is 0 (array read), `prog_req` is low and `rd_data` equals `array_rdata`.
- R2: The writes data 0xAA at address 0x555, then 0x55 at 0x2AA, then 0x90 at 0x555 set `mode` to 1 (identification). In that mode `rd_data` is 0x0020 when `rd_addr[1:0]`=00, 0x8888 when 01, and 0x0000 for 10 and 11.
- R3: The key followed by 0xA0 at 0x555 arms a single-word program. The next write raises `prog_req` for exactly one cycle with `prog_multi`=0, `prog_addr`/`prog_data` equal to that write's address and data, and `mode`=2 (busy).
- R4: The key followed by 0x20 at 0x555 raises `prog_req` for one cycle with `prog_multi`=1, and `mode` becomes 2.
- R5: Data byte 0xF0 written as the first write of a sequence, at any address, returns `mode` to 0. The three-write form (key, then 0xF0 at 0x555) does the same.
- R6: Only `wr_addr[10:0]` and `wr_data[7:0]` are compared. Set higher bits do not change the decoding.
- R7: A write that breaks the sequence returns the decoder to the first step. For example, after 0xAA@0x555, a write of 0x55 at 0x2AB followed by 0x90@0x555 leaves `mode` at 0.
- R8: While `vpp_high` is low, writes have no effect on `mode` or `prog_req`.
- R9: In identification mode, every command other than read/reset is ignored. A word-program sequence there raises no `prog_req`, and `mode` stays 1.
- R10: While `mode` is 2, all writes are ignored (including 0xF0) and `rd_data` equals `status_data`. A `prog_done` pulse sets `mode` to 0 on the next cycle.
- R11: A write that arrives in the same cycle as `prog_done` is dropped. It does not count as the first unlock write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| wr_valid | input | 1 | One-cycle write strobe |
| wr_addr | input | ADDR_W | Write address |
| wr_data | input | DATA_W | Write data |
| vpp_high | input | 1 | Programming voltage present; gates all writes |
| rd_addr | input | ADDR_W | Read address (bits 1:0 pick the identification code) |
| array_rdata | input | DATA_W | Array data for the current read |
| status_data | input | DATA_W | Status word from the programming engine |
| prog_done | input | 1 | One-cycle end-of-programming pulse |
| rd_data | output | DATA_W | Data returned for a bus read |
| mode | output | 2 | 0 array read, 1 identification, 2 busy |
| prog_req | output | 1 | One-cycle programming start request |
| prog_multi | output | 1 | Request is a multi-word session |
| prog_addr | output | ADDR_W | Captured programming address |
| prog_data | output | DATA_W | Captured programming data |

## Verification
Two functions can land in the same cycle: a bus write arriving, and the programming engine's done pulse ending the busy state. The bench sets up this overlap by raising a multi-word request first. It then drives the first unlock write in the very cycle that `prog_done` is high, and follows it with the remaining key write and the identification byte. If the early write had been counted, identification mode would be entered. The bench therefore judges the outcome by `mode` staying at 0 and `rd_data` following `array_rdata`.

// File: rtl/cmd_seq_pkg.sv
package cmd_seq_pkg;
    typedef enum logic [1:0] {
        MODE_READ  = 2'd0,
        MODE_IDENT = 2'd1,
        MODE_BUSY  = 2'd2
    } mode_e;

    typedef enum logic [1:0] {
        SEQ_IDLE = 2'd0,
        SEQ_KEY1 = 2'd1,
        SEQ_KEY2 = 2'd2,
        SEQ_ARM  = 2'd3
    } seq_e;

    localparam int CMP_AW = 11;
    localparam logic [CMP_AW-1:0] CMD_ADDR  = 11'h555;
    localparam logic [CMP_AW-1:0] KEY2_ADDR = 11'h2AA;
    localparam logic [7:0] KEY1_BYTE  = 8'hAA;
    localparam logic [7:0] KEY2_BYTE  = 8'h55;
    localparam logic [7:0] OP_RESET   = 8'hF0;
    localparam logic [7:0] OP_IDENT   = 8'h90;
    localparam logic [7:0] OP_WORD    = 8'hA0;
    localparam logic [7:0] OP_MULTI   = 8'h20;
endpackage

// File: rtl/cmd_write_classify.sv
module cmd_write_classify
    import cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    output logic              at_cmd_addr,
    output logic              at_key2_addr,
    output logic [7:0]        op_byte
);
    logic [CMP_AW-1:0] low_addr;

    always_comb begin
        low_addr     = wr_addr[CMP_AW-1:0];
        at_cmd_addr  = (low_addr == CMD_ADDR);
        at_key2_addr = (low_addr == KEY2_ADDR);
        op_byte      = wr_data[7:0];
    end
endmodule

// File: rtl/cmd_seq_fsm.sv
module cmd_seq_fsm
    import cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic              vpp_high,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              at_cmd_addr,
    input  logic              at_key2_addr,
    input  logic [7:0]        op_byte,
    input  logic              prog_done,
    output mode_e             mode,
    output logic              prog_req,
    output logic              prog_multi,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);
    typedef struct packed {
        mode_e             mode;
        seq_e              seq;
        logic              req;
        logic              multi;
        logic [ADDR_W-1:0] addr;
        logic [DATA_W-1:0] data;
    } fsm_t;

    fsm_t st_d, st_q;
    logic accept;

    always_comb begin
        st_d     = st_q;
        st_d.req = 1'b0;
        accept   = wr_valid && vpp_high;

        if (st_q.mode == MODE_BUSY) begin
            st_d.seq = SEQ_IDLE;
            if (prog_done) begin
                st_d.mode = MODE_READ;
            end
        end else if (accept) begin
            st_d.seq = SEQ_IDLE;
            unique case (st_q.seq)
                SEQ_IDLE: begin
                    if (op_byte == OP_RESET) begin
                        st_d.mode = MODE_READ;
                    end else if (at_cmd_addr && op_byte == KEY1_BYTE) begin
                        st_d.seq = SEQ_KEY1;
                    end
                end
                SEQ_KEY1: begin
                    if (at_key2_addr && op_byte == KEY2_BYTE) begin
                        st_d.seq = SEQ_KEY2;
                    end
                end
                SEQ_KEY2: begin
                    if (at_cmd_addr) begin
                        if (op_byte == OP_RESET) begin
                            st_d.mode = MODE_READ;
                        end else if (st_q.mode == MODE_READ) begin
                            if (op_byte == OP_IDENT) begin
                                st_d.mode = MODE_IDENT;
                            end else if (op_byte == OP_WORD) begin
                                st_d.seq = SEQ_ARM;
                            end else if (op_byte == OP_MULTI) begin
                                st_d.mode  = MODE_BUSY;
                                st_d.req   = 1'b1;
                                st_d.multi = 1'b1;
                                st_d.addr  = wr_addr;
                                st_d.data  = wr_data;
                            end
                        end
                    end
                end
                SEQ_ARM: begin
                    st_d.mode  = MODE_BUSY;
                    st_d.req   = 1'b1;
                    st_d.multi = 1'b0;
                    st_d.addr  = wr_addr;
                    st_d.data  = wr_data;
                end
                default: st_d.seq = SEQ_IDLE;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '{mode: MODE_READ, seq: SEQ_IDLE, req: 1'b0, multi: 1'b0,
                      addr: '0, data: '0};
        end else begin
            st_q <= st_d;
        end
    end

    assign mode       = st_q.mode;
    assign prog_req   = st_q.req;
    assign prog_multi = st_q.multi;
    assign prog_addr  = st_q.addr;
    assign prog_data  = st_q.data;

    p_req_single_r3: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |=> !prog_req);
    p_req_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
        prog_req |-> mode == MODE_BUSY);
    p_no_vpp_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!vpp_high && !prog_done) |=> ($stable(mode) && !prog_req));
    p_ident_no_prog_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_IDENT) |=> (mode != MODE_BUSY));
    p_busy_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && !prog_done) |=> (mode == MODE_BUSY));
    p_busy_exit_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (mode == MODE_BUSY && prog_done) |=> (mode == MODE_READ && !prog_req));
endmodule

// File: rtl/cmd_read_mux.sv
module cmd_read_mux
    import cmd_seq_pkg::*;
#(
    parameter int          ADDR_W = 22,
    parameter int          DATA_W = 16,
    parameter logic [15:0] MFR_ID = 16'h0020,
    parameter logic [15:0] DEV_ID = 16'h8888
) (
    input  mode_e             mode,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic [DATA_W-1:0] status_data,
    output logic [DATA_W-1:0] rd_data
);
    logic [DATA_W-1:0] id_word;

    always_comb begin
        unique case (rd_addr[1:0])
            2'b00:   id_word = DATA_W'(MFR_ID);
            2'b01:   id_word = DATA_W'(DEV_ID);
            default: id_word = '0;
        endcase
        unique case (mode)
            MODE_IDENT: rd_data = id_word;
            MODE_BUSY:  rd_data = status_data;
            default:    rd_data = array_rdata;
        endcase
    end

    always_comb begin
        if (mode == MODE_READ) begin
            a_array_path_r1: assert (rd_data == array_rdata);
        end
    end
endmodule

// File: rtl/cmd_seq_decoder.sv
module cmd_seq_decoder
    import cmd_seq_pkg::*;
#(
    parameter int ADDR_W = 22,
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_valid,
    input  logic [ADDR_W-1:0] wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              vpp_high,
    input  logic [ADDR_W-1:0] rd_addr,
    input  logic [DATA_W-1:0] array_rdata,
    input  logic [DATA_W-1:0] status_data,
    input  logic              prog_done,
    output logic [DATA_W-1:0] rd_data,
    output logic [1:0]        mode,
    output logic              prog_req,
    output logic              prog_multi,
    output logic [ADDR_W-1:0] prog_addr,
    output logic [DATA_W-1:0] prog_data
);
    logic       at_cmd_addr;
    logic       at_key2_addr;
    logic [7:0] op_byte;
    mode_e      mode_w;

    cmd_write_classify #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_classify (
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .at_cmd_addr  (at_cmd_addr),
        .at_key2_addr (at_key2_addr),
        .op_byte      (op_byte)
    );

    cmd_seq_fsm #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .wr_valid     (wr_valid),
        .vpp_high     (vpp_high),
        .wr_addr      (wr_addr),
        .wr_data      (wr_data),
        .at_cmd_addr  (at_cmd_addr),
        .at_key2_addr (at_key2_addr),
        .op_byte      (op_byte),
        .prog_done    (prog_done),
        .mode         (mode_w),
        .prog_req     (prog_req),
        .prog_multi   (prog_multi),
        .prog_addr    (prog_addr),
        .prog_data    (prog_data)
    );

    cmd_read_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_rmux (
        .mode        (mode_w),
        .rd_addr     (rd_addr),
        .array_rdata (array_rdata),
        .status_data (status_data),
        .rd_data     (rd_data)
    );

    assign mode = mode_w;
endmodule

// File: tb/cmd_seq_decoder_tb.sv
module cmd_seq_decoder_tb;
    localparam int AW = 22;
    localparam int DW = 16;
    localparam int NV = 24;

    typedef struct packed {
        logic          vpp;
        logic [AW-1:0] addr;
        logic [DW-1:0] data;
        logic [1:0]    exp_mode;
        logic          exp_req;
        logic          exp_multi;
    } vec_t;

    localparam vec_t VEC [NV] = '{
        '{1'b1, 22'h000555, 16'h00AA, 2'd0, 1'b0, 1'b0},  // R2 key1
        '{1'b1, 22'h0002AA, 16'h0055, 2'd0, 1'b0, 1'b0},  // R2 key2
        '{1'b1, 22'h000555, 16'h0090, 2'd1, 1'b0, 1'b0},  // R2 enter ident
        '{1'b1, 22'h000555, 16'h00AA, 2'd1, 1'b0, 1'b0},  // R9
        '{1'b1, 22'h0002AA, 16'h0055, 2'd1, 1'b0, 1'b0},  // R9
        '{1'b1, 22'h000555, 16'h00A0, 2'd1, 1'b0, 1'b0},  // R9 word op ignored
        '{1'b1, 22'h000100, 16'h1234, 2'd1, 1'b0, 1'b0},  // R9 no request
        '{1'b1, 22'h0007FF, 16'h00F0, 2'd0, 1'b0, 1'b0},  // R5 single reset
        '{1'b1, 22'h000555, 16'h00AA, 2'd0, 1'b0, 1'b0},  // R7
        '{1'b1, 22'h0002AB, 16'h0055, 2'd0, 1'b0, 1'b0},  // R7 bad address
        '{1'b1, 22'h000555, 16'h0090, 2'd0, 1'b0, 1'b0},  // R7 no ident
        '{1'b0, 22'h000555, 16'h00AA, 2'd0, 1'b0, 1'b0},  // R8
        '{1'b0, 22'h0002AA, 16'h0055, 2'd0, 1'b0, 1'b0},  // R8
        '{1'b0, 22'h000555, 16'h0090, 2'd0, 1'b0, 1'b0},  // R8 no ident
        '{1'b1, 22'h3FFD55, 16'hFFAA, 2'd0, 1'b0, 1'b0},  // R6
        '{1'b1, 22'h1FF2AA, 16'h3355, 2'd0, 1'b0, 1'b0},  // R6
        '{1'b1, 22'h200555, 16'hAB90, 2'd1, 1'b0, 1'b0},  // R6 ident
        '{1'b1, 22'h000555, 16'h00AA, 2'd1, 1'b0, 1'b0},  // R5 long form
        '{1'b1, 22'h0002AA, 16'h0055, 2'd1, 1'b0, 1'b0},  // R5
        '{1'b1, 22'h000555, 16'h00F0, 2'd0, 1'b0, 1'b0},  // R5 back to read
        '{1'b1, 22'h000555, 16'h00AA, 2'd0, 1'b0, 1'b0},  // R3
        '{1'b1, 22'h0002AA, 16'h0055, 2'd0, 1'b0, 1'b0},  // R3
        '{1'b1, 22'h000555, 16'h00A0, 2'd0, 1'b0, 1'b0},  // R3 arm
        '{1'b1, 22'h012345, 16'hC0DE, 2'd2, 1'b1, 1'b0}   // R3 launch
    };

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          wr_valid = 1'b0;
    logic [AW-1:0] wr_addr = '0;
    logic [DW-1:0] wr_data = '0;
    logic          vpp_high = 1'b1;
    logic [AW-1:0] rd_addr = '0;
    logic [DW-1:0] array_rdata = 16'h5A3C;
    logic [DW-1:0] status_data = 16'h0040;
    logic          prog_done = 1'b0;
    logic [DW-1:0] rd_data;
    logic [1:0]    mode;
    logic          prog_req;
    logic          prog_multi;
    logic [AW-1:0] prog_addr;
    logic [DW-1:0] prog_data;

    int checks = 0;
    int errors = 0;
    bit done_flag = 1'b0;

    always #10 clk = ~clk;

    cmd_seq_decoder #(.ADDR_W(AW), .DATA_W(DW)) u_dut (
        .clk(clk), .rst_n(rst_n), .wr_valid(wr_valid), .wr_addr(wr_addr),
        .wr_data(wr_data), .vpp_high(vpp_high), .rd_addr(rd_addr),
        .array_rdata(array_rdata), .status_data(status_data),
        .prog_done(prog_done), .rd_data(rd_data), .mode(mode),
        .prog_req(prog_req), .prog_multi(prog_multi),
        .prog_addr(prog_addr), .prog_data(prog_data)
    );

    task automatic check(input bit ok, input string req,
                         input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic do_write(input logic vpp, input logic [AW-1:0] a,
                            input logic [DW-1:0] d);
        @(negedge clk);
        vpp_high = vpp;
        wr_addr  = a;
        wr_data  = d;
        wr_valid = 1'b1;
        @(negedge clk);
        wr_valid = 1'b0;
        vpp_high = 1'b1;
    endtask

    task automatic finish_run;
        if (!done_flag) begin
            done_flag = 1'b1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1 reset state
        check(mode == 2'd0, "R1 mode", 32'(mode), 0);
        check(prog_req == 1'b0, "R1 req", 32'(prog_req), 0);
        check(rd_data == array_rdata, "R1 rd_data", 32'(rd_data), 32'(array_rdata));

        for (int i = 0; i < NV; i++) begin
            do_write(VEC[i].vpp, VEC[i].addr, VEC[i].data);
            check(mode == VEC[i].exp_mode, $sformatf("vec%0d mode", i),
                  32'(mode), 32'(VEC[i].exp_mode));
            check(prog_req == VEC[i].exp_req, $sformatf("vec%0d req", i),
                  32'(prog_req), 32'(VEC[i].exp_req));
            if (VEC[i].exp_req) begin
                check(prog_multi == VEC[i].exp_multi, "R3 multi",
                      32'(prog_multi), 32'(VEC[i].exp_multi));
                check(prog_addr == VEC[i].addr, "R3 addr",
                      32'(prog_addr), 32'(VEC[i].addr));
                check(prog_data == VEC[i].data, "R3 data",
                      32'(prog_data), 32'(VEC[i].data));
            end
        end

        // R3 request lasts one cycle
        @(negedge clk);
        check(prog_req == 1'b0, "R3 pulse width", 32'(prog_req), 0);
        // R10 busy reads status, ignores reset byte
        check(rd_data == status_data, "R10 status read", 32'(rd_data), 32'(status_data));
        do_write(1'b1, 22'h000123, 16'h00F0);
        check(mode == 2'd2, "R10 reset ignored", 32'(mode), 2);
        @(negedge clk); prog_done = 1'b1;
        @(negedge clk); prog_done = 1'b0;
        check(mode == 2'd0, "R10 done exit", 32'(mode), 0);

        // R2 identification codes
        do_write(1'b1, 22'h000555, 16'h00AA);
        do_write(1'b1, 22'h0002AA, 16'h0055);
        do_write(1'b1, 22'h000555, 16'h0090);
        rd_addr = 22'h3FFFFC; #1;
        check(rd_data == 16'h0020, "R2 maker code", 32'(rd_data), 32'h20);
        rd_addr = 22'h000001; #1;
        check(rd_data == 16'h8888, "R2 device code", 32'(rd_data), 32'h8888);
        rd_addr = 22'h000002; #1;
        check(rd_data == 16'h0000, "R2 other code", 32'(rd_data), 0);
        do_write(1'b1, 22'h000000, 16'h00F0);

        // R4 multi-word start
        do_write(1'b1, 22'h000555, 16'h00AA);
        do_write(1'b1, 22'h0002AA, 16'h0055);
        do_write(1'b1, 22'h000555, 16'h0020);
        check(prog_req == 1'b1, "R4 req", 32'(prog_req), 1);
        check(prog_multi == 1'b1, "R4 multi", 32'(prog_multi), 1);
        check(mode == 2'd2, "R4 busy", 32'(mode), 2);

        // R11 write coincident with done is dropped
        @(negedge clk);
        prog_done = 1'b1;
        wr_addr = 22'h000555; wr_data = 16'h00AA; wr_valid = 1'b1;
        @(negedge clk);
        prog_done = 1'b0; wr_valid = 1'b0;
        check(mode == 2'd0, "R11 exit", 32'(mode), 0);
        do_write(1'b1, 22'h0002AA, 16'h0055);
        do_write(1'b1, 22'h000555, 16'h0090);
        check(mode == 2'd0, "R11 mode", 32'(mode), 0);
        array_rdata = 16'h1357; #1;
        check(rd_data == 16'h1357, "R11 array path", 32'(rd_data), 32'h1357);

        finish_run();
    end
endmodule